// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel data buses, side A and side B, and can forward a word from either side to the other. Every tri-state bus is split into an input vector, an output vector and a single output-enable, which keeps the block synthesizable. The outer logic joins these vectors at the pad or bus level.

Each side has its own holding register with its own capture clock. Each register samples its bus on every rising edge of that clock, whatever the output controls are doing. An active-low enable and a direction input choose which bus, if either, the block drives. For each direction, a select input chooses what appears on the driven bus: the live word from the opposite bus, passed through with no delay, or the word held in the opposite side's register.

There is no reset. The holding registers start unknown until their first capture edge.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab`, the A-side register loads the value present on `a_in`.
- R2: On each rising edge of `clk_ba`, the B-side register loads the value present on `b_in`.
- R3: Register loading takes place for every setting of `oe_n`, `dir`, `sel_ab` and `sel_ba`, including isolation. A word captured while isolated is the word later shown in stored mode.
- R4: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R5: While `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0.
- R6: While `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0.
- R7: While `b_oe` is 1 and `sel_ab` is 0, `b_out` equals the current `a_in`, combinationally and in the same cycle.
- R8: While `b_oe` is 1 and `sel_ab` is 1, `b_out` equals the A-side register.
- R9: While `a_oe` is 1, `a_out` equals the current `b_in` when `sel_ba` is 0, and equals the B-side register when `sel_ba` is 1.
- R10: In stored mode, a capture edge on the source side puts the newly captured word on the driven bus right after that edge.
- R11: `a_oe` and `b_oe` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| sel_ab | input | 1 | Source for bus B: 0 live `a_in`, 1 A-side register |
| sel_ba | input | 1 | Source for bus A: 0 live `b_in`, 1 B-side register |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value to drive onto bus A |
| a_oe | output | 1 | Bus A driver enable |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value to drive onto bus B |
| b_oe | output | 1 | Bus B driver enable |

## Verification
The hardest case to reach is a word that was captured while both buses were isolated and is only shown much later in stored mode. In that case the capture and the display are separated by changes to the direction and enable settings.

The stimulus first loads both registers during isolation and then drives different live values on both buses. It then opens each direction with its select set to stored, so a register that missed an isolated capture would show a stale word.

A long random phase follows. It mixes capture pulses on either clock with every setting of the controls, including pulses on the same step as a stored-mode read. The bench model keeps its own copy of each register and checks every output on every step.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_TO_A = 2'b01,
    DRV_TO_B = 2'b10
  } drive_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  // Loading is never gated: every edge captures.
  always_comb q_nxt = d;

  always_ff @(posedge clk) q <= q_nxt;

  // R1, R2, R3
  property capture_p;
    @(posedge clk) 1'b1 |=> (q == $past(d));
  endproperty
  capture_chk: assert property (capture_p);
endmodule

// File: rtl/xcvr_drive_dec.sv
module xcvr_drive_dec
  import xcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_e drv
);
  always_comb begin
    if (oe_n)     drv = DRV_NONE;
    else if (dir) drv = DRV_TO_B;
    else          drv = DRV_TO_A;
  end
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux #(
  parameter int W = 8
) (
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  always_comb y = use_stored ? stored : live;
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam int NSIDE = 2;

  logic [W-1:0] held_a;
  logic [W-1:0] held_b;
  drive_e       drv;

  logic         side_clk [NSIDE];
  logic [W-1:0] side_d   [NSIDE];
  logic [W-1:0] side_q   [NSIDE];

  // Side 0 holds the A bus, side 1 holds the B bus.
  always_comb begin
    side_clk[0] = clk_ab;
    side_clk[1] = clk_ba;
    side_d[0]   = a_in;
    side_d[1]   = b_in;
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    xcvr_store #(.W(W)) u_store (
      .clk (side_clk[s]),
      .d   (side_d[s]),
      .q   (side_q[s])
    );
  end

  assign held_a = side_q[0];
  assign held_b = side_q[1];

  xcvr_drive_dec u_dec (
    .oe_n (oe_n),
    .dir  (dir),
    .drv  (drv)
  );

  assign a_oe = (drv == DRV_TO_A);
  assign b_oe = (drv == DRV_TO_B);

  xcvr_src_mux #(.W(W)) u_mux_b (
    .use_stored (sel_ab),
    .live       (a_in),
    .stored     (held_a),
    .y          (b_out)
  );

  xcvr_src_mux #(.W(W)) u_mux_a (
    .use_stored (sel_ba),
    .live       (b_in),
    .stored     (held_b),
    .y          (a_out)
  );

  always_comb begin
    // R11
    oe_excl_chk: assert (!(a_oe && b_oe));
    // R4
    if (oe_n) begin
      iso_quiet_chk: assert (!a_oe && !b_oe);
    end
    // R5
    if (!oe_n && dir) begin
      drive_b_chk: assert (b_oe && !a_oe);
    end
    // R6
    if (!oe_n && !dir) begin
      drive_a_chk: assert (a_oe && !b_oe);
    end
    // R7
    if (b_oe && !sel_ab) begin
      live_b_chk: assert (b_out == a_in);
    end
    // R9
    if (a_oe && !sel_ba) begin
      live_a_chk: assert (a_out == b_in);
    end
  end
endmodule

// File: tb/reg_bus_xcvr_test.sv
`timescale 1ns/100ps
module reg_bus_xcvr_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         clk_ab = 1'b0, clk_ba = 1'b0;
  logic         oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  reg_bus_xcvr #(.W(W)) uut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench-side model of both holding registers.
  int  m_a, m_b;
  bit  known_a = 0, known_b = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One step: inputs at negedge, optional capture pulses, then compare.
  task automatic step(input bit n_oe, input bit d, input bit sab, input bit sba,
                      input int av, input int bv, input bit p_ab, input bit p_ba,
                      input string tag);
    bit exp_aoe, exp_boe;
    @(negedge clk);
    oe_n = n_oe; dir = d; sel_ab = sab; sel_ba = sba;
    a_in = av[W-1:0]; b_in = bv[W-1:0];
    #0.5;
    if (p_ab) begin clk_ab = 1'b1; m_a = av & 8'hFF; known_a = 1; end
    if (p_ba) begin clk_ba = 1'b1; m_b = bv & 8'hFF; known_b = 1; end
    #0.5;
    clk_ab = 1'b0; clk_ba = 1'b0;
    #0.5;
    exp_aoe = !n_oe && !d;
    exp_boe = !n_oe && d;
    chk({tag, " R4/R5/R6 a_oe"}, a_oe, exp_aoe);
    chk({tag, " R4/R5/R6 b_oe"}, b_oe, exp_boe);
    chk({tag, " R11 exclusive"}, a_oe & b_oe, 0);
    if (exp_boe) begin
      if (!sab)         chk({tag, " R7 live to B"}, b_out, av & 8'hFF);
      else if (known_a) chk({tag, (p_ab ? " R10 capture+show B" : " R8 stored to B")}, b_out, m_a);
    end
    if (exp_aoe) begin
      if (!sba)         chk({tag, " R9 live to A"}, a_out, bv & 8'hFF);
      else if (known_b) chk({tag, (p_ba ? " R10 capture+show A" : " R9 stored to A")}, a_out, m_b);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // Isolation state, no captures yet: R4
    step(1, 0, 0, 0, 8'h11, 8'h22, 0, 0, "iso");
    step(1, 1, 1, 1, 8'h33, 8'h44, 0, 0, "iso");
    // R3: load both registers while isolated, R1 and R2
    step(1, 1, 1, 1, 8'hA5, 8'h5A, 1, 1, "iso-load");
    // R8 / R3: show isolated capture on B while a_in differs
    step(0, 1, 1, 0, 8'h00, 8'hFF, 0, 0, "R1 R3 stored B");
    // R9 stored to A
    step(0, 0, 0, 1, 8'hFF, 8'h00, 0, 0, "R2 R3 stored A");
    // R7 live paths
    step(0, 1, 0, 0, 8'h3C, 8'hC3, 0, 0, "live B");
    step(0, 1, 0, 0, 8'h00, 8'hC3, 0, 0, "live B zero");
    step(0, 0, 0, 0, 8'h3C, 8'hFF, 0, 0, "live A");
    // R10 capture and show on the same edge
    step(0, 1, 1, 0, 8'h77, 8'h00, 1, 0, "R10 B");
    step(0, 0, 0, 1, 8'h00, 8'h99, 0, 1, "R10 A");
    // capture on the side being driven into does not disturb the stored value shown
    step(0, 1, 1, 0, 8'h12, 8'hEE, 0, 1, "R8 other clk");
    // Random sweep
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[0], r[1], r[2], r[3], int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), r[4], r[5], "rand");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule